// File: doc/BRIEF.md
# Manchester II Frame Encoder

This block turns one host word into a Manchester II line frame. It runs from one clock at twice the bit rate, so each clock cycle is one half-bit slot on the line. A frame opens with a sync waveform three bit periods long, which is either a command sync or a data sync. A programmable number of data bits follows, and one parity bit closes the frame. The encoder does not hold the word itself. It asks the host for each data bit with a one-cycle request pulse, and it samples the host's serial input on that pulse.

The line appears as two complementary outputs. Both outputs rest low whenever no frame is running or the line inhibit is raised. A free-running divide-by-six output is also provided for use as a slower timing reference. An asynchronous active-low reset aborts any frame and returns the block to idle.

Top module: `mfe_frame_enc`

## Requirements
- R1: While reset is held low, and after it is released with enable low, bip_one, bip_zero, shift_clk, send_data and div6_out are all 0.
- R2: A rising clock edge that sees enable=1 while idle starts a frame. Half-bit slot 0 is on the line in the following cycle. The frame lasts 2*(N+4) cycles, and the block is idle afterwards if enable was low at the last slot.
- R3: The sync takes slots 0 to 5. With cmd_sync_sel=1 (command sync), bip_one is high for slots 0 to 2 and low for slots 3 to 5. With cmd_sync_sel=0 (data sync), the pattern is reversed.
- R4: Data bit k occupies slots 6+2k and 7+2k. A 1 is high then low on bip_one, and a 0 is low then high. Bits go out in the order the host supplies them.
- R5: shift_clk is a one-cycle pulse in each odd slot from 5 to 2N+3, which gives exactly N pulses. ser_in is sampled at the clock edge that ends each pulse and is sent as the next data bit. send_data is high without a break from slot 5 through slot 2N+3.
- R6: The parity bit occupies the last two slots and is encoded like a data bit. With odd_parity_sel=0, the data bits plus the parity bit hold an even number of ones. With odd_parity_sel=1, they hold an odd number. Parity covers the data bits only.
- R7: The data-bit count N is the word_len value, raised to 2 when it is below 2 and lowered to 28 when it is above 28. N, cmd_sync_sel and odd_parity_sel are latched when the frame starts, and later changes to them have no effect on that frame.
- R8: During a frame with the inhibit low, bip_zero is the complement of bip_one. When idle, both outputs are low.
- R9: line_inhibit=1 forces bip_one and bip_zero low while framing and the shift_clk/send_data handshake carry on unchanged.
- R10: If enable is high at the last slot of a frame, slot 0 of a new frame follows in the next cycle with no idle gap.
- R11: div6_out toggles every 3 clock cycles, which gives a period of 6 cycles. It runs without regard to framing.
- R12: Pulling rst_n low in the middle of a frame drives all outputs low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Frame request, sampled when idle and at the last slot |
| cmd_sync_sel | input | 1 | 1 selects command sync, 0 selects data sync |
| odd_parity_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| word_len | input | 5 | Requested data-bit count (clamped to 2..28) |
| ser_in | input | 1 | Serial data from the host, sampled on shift_clk |
| line_inhibit | input | 1 | Forces both line outputs low |
| bip_one | output | 1 | True-polarity Manchester output |
| bip_zero | output | 1 | Complement Manchester output |
| shift_clk | output | 1 | One-cycle data request pulse |
| send_data | output | 1 | High across the data-request window |
| div6_out | output | 1 | Clock divided by six |

## Verification
All outputs are combinational decodes of registered state. A slot value therefore becomes visible in the cycle after the edge that set it. Slot 0 is visible one cycle after the edge that sees enable, and slot i is visible i cycles after that. A bit supplied during a request pulse appears on the line in the very next slot. The bench drives inputs and samples outputs at the falling edge, and it compares every slot against a per-slot expectation built from the slot index. The frame-end check falls exactly 2*(N+4) cycles after the start. The reset check is taken one time step after rst_n falls, which tests that the reset acts asynchronously.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  localparam int LEN_W      = 5;
  localparam int MIN_BITS   = 2;
  localparam int MAX_BITS   = 28;
  localparam int SYNC_HALF  = 3;
  localparam int LEAD_SLOTS = 2 * SYNC_HALF;
  localparam int SLOT_W     = $clog2(2 * (MAX_BITS + SYNC_HALF + 1));

  typedef logic [LEN_W-1:0]  len_t;
  typedef logic [SLOT_W-1:0] slot_t;

  // Clamp a requested data-bit count into the supported range.
  function automatic len_t fit_len(len_t w);
    if (w < len_t'(MIN_BITS)) return len_t'(MIN_BITS);
    if (w > len_t'(MAX_BITS)) return len_t'(MAX_BITS);
    return w;
  endfunction

  // Index of the last half-bit slot of a frame carrying n data bits.
  function automatic slot_t final_slot(len_t n);
    return slot_t'({n, 1'b0}) + slot_t'(LEAD_SLOTS + 1);
  endfunction

  // Sync level: the selected polarity for the first half, then the inverse.
  function automatic logic sync_level(logic cmd, slot_t h);
    return (h < slot_t'(SYNC_HALF)) ? cmd : ~cmd;
  endfunction

  // Span in which data requests are issued: one slot ahead of each data bit.
  function automatic logic in_req_window(slot_t h, len_t n);
    return (h >= slot_t'(LEAD_SLOTS - 1)) &&
           (h <= slot_t'({n, 1'b0}) + slot_t'(LEAD_SLOTS - 3));
  endfunction

  function automatic logic is_req_slot(slot_t h, len_t n);
    return h[0] && in_req_window(h, n);
  endfunction

  // Manchester half: true value in the even half, complement in the odd half.
  function automatic logic manch_half(logic b, slot_t h);
    return b ^ h[0];
  endfunction
endpackage

// File: rtl/mfe_seq.sv
module mfe_seq
  import mfe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  cmd_sel,
  input  logic  odd_sel,
  input  len_t  wlen,
  output logic  busy,
  output slot_t slot,
  output len_t  nbits,
  output logic  cmd_q,
  output logic  odd_q,
  output logic  load
);
  slot_t last;
  logic  at_end;

  assign last   = final_slot(nbits);
  assign at_end = busy && (slot == last);
  assign load   = enable && (!busy || at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      slot  <= '0;
      nbits <= len_t'(MIN_BITS);
      cmd_q <= 1'b0;
      odd_q <= 1'b0;
    end else if (load) begin
      busy  <= 1'b1;
      slot  <= '0;
      nbits <= fit_len(wlen);
      cmd_q <= cmd_sel;
      odd_q <= odd_sel;
    end else if (at_end) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (busy) begin
      slot <= slot + slot_t'(1);
    end
  end

  // R2: a request seen while idle opens slot 0 on the next cycle
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && enable) |=> (busy && slot == '0));
  // R7: slot index never runs past the frame end
  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot <= last));
  // R7: latched length is frozen inside a frame
  p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot != '0) |-> $stable(nbits));
  // R7: latched length lies in the legal range
  p_len_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (nbits >= len_t'(MIN_BITS) && nbits <= len_t'(MAX_BITS)));
endmodule

// File: rtl/mfe_bits.sv
module mfe_bits
  import mfe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  busy,
  input  slot_t slot,
  input  len_t  nbits,
  input  logic  odd_q,
  input  logic  load,
  input  logic  ser_in,
  output logic  shift_clk,
  output logic  send_data,
  output logic  data_bit,
  output logic  par_bit
);
  logic par_acc;

  assign shift_clk = busy && is_req_slot(slot, nbits);
  assign send_data = busy && in_req_window(slot, nbits);
  assign par_bit   = par_acc ^ odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_bit <= 1'b0;
      par_acc  <= 1'b0;
    end else if (load) begin
      par_acc <= 1'b0;
    end else if (shift_clk) begin
      data_bit <= ser_in;
      par_acc  <= par_acc ^ ser_in;
    end
  end

  // R5: each request pulse sits inside the send window
  p_req_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |-> send_data);
  // R5: request pulses are one cycle wide
  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |=> !shift_clk);
  // R5: the host bit offered on a pulse is the bit that goes out next
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |=> (data_bit == $past(ser_in)));
endmodule

// File: rtl/mfe_div.sv
module mfe_div #(
  parameter int DIV_HALF = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic q
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (cnt == CW'(DIV_HALF - 1)) begin
      cnt <= '0;
      q   <= ~q;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R11: after a toggle the output holds for at least one more cycle
  p_div_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |=> $stable(q));
endmodule

// File: rtl/mfe_frame_enc.sv
module mfe_frame_enc
  import mfe_pkg::*;
#(
  parameter int DIV_HALF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cmd_sync_sel,
  input  logic             odd_parity_sel,
  input  logic [LEN_W-1:0] word_len,
  input  logic             ser_in,
  input  logic             line_inhibit,
  output logic             bip_one,
  output logic             bip_zero,
  output logic             shift_clk,
  output logic             send_data,
  output logic             div6_out
);
  logic  busy, cmd_q, odd_q, load, data_bit, par_bit, lvl, drive;
  slot_t slot;
  len_t  nbits;

  mfe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_sel(cmd_sync_sel),
    .odd_sel(odd_parity_sel), .wlen(word_len), .busy(busy), .slot(slot),
    .nbits(nbits), .cmd_q(cmd_q), .odd_q(odd_q), .load(load)
  );

  mfe_bits u_bits (
    .clk(clk), .rst_n(rst_n), .busy(busy), .slot(slot), .nbits(nbits),
    .odd_q(odd_q), .load(load), .ser_in(ser_in), .shift_clk(shift_clk),
    .send_data(send_data), .data_bit(data_bit), .par_bit(par_bit)
  );

  mfe_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .q(div6_out)
  );

  always_comb begin
    if (slot < slot_t'(LEAD_SLOTS))
      lvl = sync_level(cmd_q, slot);
    else if (slot < final_slot(nbits) - slot_t'(1))
      lvl = manch_half(data_bit, slot);
    else
      lvl = manch_half(par_bit, slot);
  end

  assign drive    = busy && !line_inhibit;
  assign bip_one  = drive & lvl;
  assign bip_zero = drive & ~lvl;

  // R8: nothing moves while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bip_one && !bip_zero && !shift_clk && !send_data));
  // R3: first sync half carries the latched sync polarity
  p_sync_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot == '0 && !line_inhibit) |-> (bip_one == cmd_q));
  // R9: inhibit silences both line outputs
  p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_inhibit |-> (!bip_one && !bip_zero));
  // R4: every bit cell has a mid-cell transition
  p_midbit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !line_inhibit && !$past(line_inhibit) &&
     slot >= slot_t'(LEAD_SLOTS) && slot[0]) |-> (bip_one != $past(bip_one)));
endmodule

// File: tb/sim_mfe_frame_enc.sv
module sim_mfe_frame_enc;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, enable, cmd_sync_sel, odd_parity_sel, ser_in, line_inhibit;
  logic [4:0] word_len;
  logic       bip_one, bip_zero, shift_clk, send_data, div6_out;
  int n_run = 0;
  int n_fail = 0;

  mfe_frame_enc u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_sync_sel(cmd_sync_sel),
    .odd_parity_sel(odd_parity_sel), .word_len(word_len), .ser_in(ser_in),
    .line_inhibit(line_inhibit), .bip_one(bip_one), .bip_zero(bip_zero),
    .shift_clk(shift_clk), .send_data(send_data), .div6_out(div6_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {word_len, cmd, odd, word[27:0], inhibit}
  localparam int NV = 7;
  localparam logic [35:0] VEC [NV] = '{
    {5'd16, 1'b1, 1'b0, 28'h000A5C3, 1'b0},
    {5'd2,  1'b0, 1'b1, 28'h0000003, 1'b0},
    {5'd28, 1'b1, 1'b1, 28'hFFFFFFF, 1'b0},
    {5'd0,  1'b0, 1'b0, 28'h0000001, 1'b0},
    {5'd31, 1'b1, 1'b0, 28'h5A5A5A5, 1'b0},
    {5'd7,  1'b0, 1'b1, 28'h0000055, 1'b1},
    {5'd9,  1'b1, 1'b0, 28'h0000136, 1'b0}
  };

  function automatic int eff_len(int w);
    if (w < 2) return 2;
    if (w > 28) return 28;
    return w;
  endfunction

  // {bip_one, bip_zero, shift_clk, send_data} for half-slot i
  function automatic logic [3:0] expect_slot(int i, int n, bit cmd, bit odd, logic [27:0] word, bit inh);
    bit lvl, pb, sh, sd;
    if (i < 6) lvl = cmd ? (i < 3) : (i >= 3);
    else if (i < 6 + 2*n) lvl = (i % 2 == 0) ? word[(i-6)/2] : !word[(i-6)/2];
    else begin
      pb = odd;
      for (int k = 0; k < n; k++) pb ^= word[k];
      lvl = (i % 2 == 0) ? pb : !pb;
    end
    sd = (i >= 5) && (i <= 2*n + 3);
    sh = sd && (i % 2 == 1);
    return {inh ? 1'b0 : lvl, inh ? 1'b0 : !lvl, sh, sd};
  endfunction

  function automatic string tag_of(int i, int n, bit inh);
    if (inh) return "R9";
    if (i < 6) return "R3";
    if (i < 6 + 2*n) return "R4/R5";
    return "R6";
  endfunction

  task automatic start(input logic [4:0] wl, input bit cmd, input bit odd, input bit inh);
    word_len = wl; cmd_sync_sel = cmd; odd_parity_sel = odd; line_inhibit = inh;
    enable = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  // Called at the falling edge where slot 0 is visible; returns one cycle after the last slot.
  task automatic play(input int n, input bit cmd, input bit odd, input logic [27:0] word,
                      input bit inh, input bit hold, input logic [4:0] wl);
    logic [3:0] e;
    for (int i = 0; i < 2*n + 8; i++) begin
      if (i == 0 && !hold) enable = 1'b0;
      if (i == 3 && !hold) begin
        word_len = ~wl; cmd_sync_sel = !cmd; odd_parity_sel = !odd;  // R7: no effect mid-frame
      end
      e = expect_slot(i, n, cmd, odd, word, inh);
      if (e[1]) ser_in = word[(i-5)/2];
      chk({bip_one, bip_zero, shift_clk, send_data} == e, tag_of(i, n, inh),
          {28'd0, bip_one, bip_zero, shift_clk, send_data}, {28'd0, e});
      @(negedge clk);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({bip_one, bip_zero, shift_clk, send_data} == 4'b0, req,
        {28'd0, bip_one, bip_zero, shift_clk, send_data}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic prev;
    rst_n = 1'b0; enable = 1'b0; cmd_sync_sel = 1'b0; odd_parity_sel = 1'b0;
    word_len = 5'd2; ser_in = 1'b0; line_inhibit = 1'b0;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk({bip_one, bip_zero, shift_clk, send_data, div6_out} == 5'b0, "R1",
        {27'd0, bip_one, bip_zero, shift_clk, send_data, div6_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");

    // Table walk: R2..R9 across lengths, sync types, parities, clamping, inhibit
    for (int v = 0; v < NV; v++) begin
      start(VEC[v][35:31], VEC[v][30], VEC[v][29], VEC[v][0]);
      play(eff_len(int'(VEC[v][35:31])), VEC[v][30], VEC[v][29], VEC[v][28:1],
           VEC[v][0], 1'b0, VEC[v][35:31]);
      chk_idle("R2");  // frame ended exactly after 2*(N+4) slots
      line_inhibit = 1'b0;
      @(negedge clk);
      chk_idle("R8");
    end

    // R10: back-to-back frames
    start(5'd4, 1'b0, 1'b1, 1'b0);
    play(4, 1'b0, 1'b1, 28'h9, 1'b0, 1'b1, 5'd4);
    play(4, 1'b0, 1'b1, 28'h6, 1'b0, 1'b0, 5'd4);  // R10 slot 0 follows at once
    chk_idle("R10");

    // R11: divide-by-six output
    prev = div6_out;
    for (int j = 0; j < 8 && div6_out == prev; j++) @(negedge clk);
    prev = div6_out;
    @(negedge clk); chk(div6_out == prev, "R11", {31'd0, div6_out}, {31'd0, prev});
    @(negedge clk); chk(div6_out == prev, "R11", {31'd0, div6_out}, {31'd0, prev});
    @(negedge clk); chk(div6_out == !prev, "R11", {31'd0, div6_out}, {31'd0, !prev});

    // R12: asynchronous abort mid-frame
    start(5'd10, 1'b1, 1'b0, 1'b0);
    enable = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({bip_one, bip_zero, shift_clk, send_data, div6_out} == 5'b0, "R12",
        {27'd0, bip_one, bip_zero, shift_clk, send_data, div6_out}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R12");
    start(5'd3, 1'b1, 1'b0, 1'b0);
    play(3, 1'b1, 1'b0, 28'h5, 1'b0, 1'b0, 5'd3);
    chk_idle("R2");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule